// File: doc/BRIEF.md
# Global Interrupt-Channel Access Router

This block sits between the host bus and four UART channels. It gives the host one small set of global pseudo-registers, and these always act on whichever channel is raising the current interrupt. So the interrupt handler never has to work out a per-channel address.

When interrupt acknowledge starts, the block latches a current-interrupt record from the winning bid. The record holds the channel code, the three-bit interrupt type and a three-bit byte count taken from that channel's counters. The record then stays fixed until the next acknowledge.

Host accesses at four fixed addresses do the following:
- read the whole record;
- read the channel code alone;
- read the byte count alone;
- read from the interrupting channel's receive FIFO, or write to its transmit FIFO, at one shared address.

An access that does not match the latched interrupt cause is neutralised. A receive read returns all ones and pops nothing. A transmit write is dropped.

Top module: `gir_router`

## Requirements
- R1: After reset the record is channel 0, type 3'b000, count 0, so a read at 8'h28 returns 8'h00. Type 3'b000 is neither a receiver nor a transmitter cause.
- R2: In the clock cycle where `iack_start` is high, the record takes `win_chan` and `win_type`. Every counter/timer channel code (01, 11) passes through unchanged. With `iack_start` low, the record does not change, whatever happens on the bid or count inputs.
- R3: The captured count depends on the low two type bits:
  - 2'b11 (receiver): the count is the winning channel's `rx_count`.
  - 2'b10 (transmitter): the count is the winning channel's `tx_space`.
  - any other value: the count is 0.
  Channel n occupies bits [3n+2:3n] of each count bus.
- R4: A read at 8'h28 returns {chan[7:6], type[5:3], count[2:0]}.
- R5: A read at 8'h29 returns the channel code in bits [1:0] with zeros above.
- R6: A read at 8'h2A returns the count in bits [2:0] with zeros above.
- R7: A read at 8'h2B with a receiver type pulses only `rx_pop[chan]` in that cycle. It returns that channel's byte from `rx_data`, where channel n is bits [8n+7:8n].
- R8: A read at 8'h2B with a non-receiver type returns 8'hFF and leaves `rx_pop` all zero.
- R9: A write at 8'h2B with a transmitter type pulses only `tx_push[chan]` and drives `bus_wdata` onto `tx_wdata`.
- R10: A write at 8'h2B with a non-transmitter type leaves `tx_push` all zero.
- R11: The following return 8'h00 on `bus_rdata` and cause no pop or push:
  - any access to another address;
  - a write to a read-only address;
  - a cycle with `bus_sel` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iack_start | input | 1 | High in the cycle interrupt acknowledge begins |
| win_chan | input | 2 | Channel code of the winning interrupt bid |
| win_type | input | 3 | Type code of the winning interrupt bid |
| rx_count | input | 12 | Per-channel received-byte counts, 3 bits each |
| tx_space | input | 12 | Per-channel free transmit slots, 3 bits each |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| rx_data | input | 32 | Head byte of each receive FIFO, 8 bits each |
| rx_pop | output | 4 | One-cycle pop per receive FIFO |
| tx_push | output | 4 | One-cycle push per transmit FIFO |
| tx_wdata | output | 8 | Byte to push into the selected transmit FIFO |

## Verification
The assertions watch several properties on every cycle:
- at most one pop and at most one push are active;
- a pop occurs only under a receiver record, and a push only under a transmitter record;
- a global receive read with no receiver cause returns 8'hFF;
- the record is frozen outside acknowledge, and picks up the bid channel and type exactly one cycle after `iack_start`.

Only the bench scenarios can show the following:
- that the count selection and the padding of the three read-back bytes match the required bit layouts;
- that the popped byte belongs to the right channel;
- that unmapped and read-only accesses are inert.

// File: rtl/gir_pkg.sv
package gir_pkg;
  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] TYPE_IDLE = 3'b000;

  function automatic logic type_is_rx(input logic [TYPE_W-1:0] t);
    return t[1:0] == 2'b11;
  endfunction

  function automatic logic type_is_tx(input logic [TYPE_W-1:0] t);
    return t[1:0] == 2'b10;
  endfunction

  // count source: 0 = none, 1 = receive level, 2 = transmit space
  function automatic logic [1:0] count_source(input logic [TYPE_W-1:0] t);
    if (type_is_rx(t)) return 2'd1;
    if (type_is_tx(t)) return 2'd2;
    return 2'd0;
  endfunction
endpackage

// File: rtl/gir_record.sv
module gir_record
  import gir_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CNTW = 3,
  localparam int CW  = $clog2(NCH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  iack_start,
  input  logic [CW-1:0]         win_chan,
  input  logic [TYPE_W-1:0]     win_type,
  input  logic [NCH*CNTW-1:0]   rx_count,
  input  logic [NCH*CNTW-1:0]   tx_space,
  output logic [CW-1:0]         rec_chan,
  output logic [TYPE_W-1:0]     rec_type,
  output logic [CNTW-1:0]       rec_cnt
);
  logic [CNTW-1:0] sel_rx_cnt, sel_tx_cnt, cap_cnt;

  assign sel_rx_cnt = rx_count[win_chan*CNTW +: CNTW];
  assign sel_tx_cnt = tx_space[win_chan*CNTW +: CNTW];

  always_comb begin
    case (count_source(win_type))
      2'd1:    cap_cnt = sel_rx_cnt;
      2'd2:    cap_cnt = sel_tx_cnt;
      default: cap_cnt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_chan <= '0;
      rec_type <= TYPE_IDLE;
      rec_cnt  <= '0;
    end else if (iack_start) begin
      rec_chan <= win_chan;
      rec_type <= win_type;
      rec_cnt  <= cap_cnt;
    end
  end

  AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_start |=> ($stable(rec_chan) && $stable(rec_type) && $stable(rec_cnt))); // R2
  AST_REC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_start |=> (rec_chan == $past(win_chan) && rec_type == $past(win_type))); // R2
  AST_CNT_ZERO_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_start && !type_is_rx(win_type) && !type_is_tx(win_type)) |=> rec_cnt == '0); // R3
endmodule

// File: rtl/gir_decode.sv
module gir_decode #(
  parameter int AW = 8,
  parameter logic [AW-1:0] A_REC  = 8'h28,
  parameter logic [AW-1:0] A_CHAN = 8'h29,
  parameter logic [AW-1:0] A_CNT  = 8'h2A,
  parameter logic [AW-1:0] A_DATA = 8'h2B
) (
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  output logic          rd_rec,
  output logic          rd_chan,
  output logic          rd_cnt,
  output logic          rd_data,
  output logic          wr_data
);
  logic rd_cyc, wr_cyc;

  assign rd_cyc  = bus_sel && !bus_wr;
  assign wr_cyc  = bus_sel && bus_wr;
  assign rd_rec  = rd_cyc && (bus_addr == A_REC);
  assign rd_chan = rd_cyc && (bus_addr == A_CHAN);
  assign rd_cnt  = rd_cyc && (bus_addr == A_CNT);
  assign rd_data = rd_cyc && (bus_addr == A_DATA);
  assign wr_data = wr_cyc && (bus_addr == A_DATA);

  always_comb begin
    AST_ONE_STROBE: assert ($onehot0({rd_rec, rd_chan, rd_cnt, rd_data, wr_data})); // R11
  end
endmodule

// File: rtl/gir_steer.sv
module gir_steer
  import gir_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_data,
  input  logic               wr_data,
  input  logic [CW-1:0]      rec_chan,
  input  logic [TYPE_W-1:0]  rec_type,
  input  logic [NCH*DW-1:0]  rx_data,
  input  logic [DW-1:0]      bus_wdata,
  output logic [NCH-1:0]     rx_pop,
  output logic [NCH-1:0]     tx_push,
  output logic [DW-1:0]      tx_wdata,
  output logic [DW-1:0]      data_rd
);
  logic rx_ok, tx_ok;

  assign rx_ok = rd_data && type_is_rx(rec_type);
  assign tx_ok = wr_data && type_is_tx(rec_type);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign rx_pop[c]  = rx_ok && (rec_chan == CW'(c));
    assign tx_push[c] = tx_ok && (rec_chan == CW'(c));
  end

  assign tx_wdata = bus_wdata;
  assign data_rd  = rx_ok ? rx_data[rec_chan*DW +: DW] : {DW{1'b1}};

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_pop)); // R7
  AST_PUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_push)); // R9
  AST_POP_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop != '0) |-> type_is_rx(rec_type)); // R8
  AST_PUSH_NEEDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push != '0) |-> type_is_tx(rec_type)); // R10
endmodule

// File: rtl/gir_router.sv
module gir_router
  import gir_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int CNTW = 3,
  localparam int CW  = $clog2(NCH),
  localparam int REC_W = CW + TYPE_W + CNTW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 iack_start,
  input  logic [CW-1:0]        win_chan,
  input  logic [TYPE_W-1:0]    win_type,
  input  logic [NCH*CNTW-1:0]  rx_count,
  input  logic [NCH*CNTW-1:0]  tx_space,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [NCH*DW-1:0]    rx_data,
  output logic [NCH-1:0]       rx_pop,
  output logic [NCH-1:0]       tx_push,
  output logic [DW-1:0]        tx_wdata
);
  logic [CW-1:0]     rec_chan;
  logic [TYPE_W-1:0] rec_type;
  logic [CNTW-1:0]   rec_cnt;
  logic              rd_rec, rd_chan, rd_cnt, rd_data, wr_data;
  logic [DW-1:0]     data_rd;
  logic [REC_W-1:0]  rec_word;

  gir_record #(.NCH(NCH), .CNTW(CNTW)) u_record (
    .clk(clk), .rst_n(rst_n), .iack_start(iack_start),
    .win_chan(win_chan), .win_type(win_type),
    .rx_count(rx_count), .tx_space(tx_space),
    .rec_chan(rec_chan), .rec_type(rec_type), .rec_cnt(rec_cnt)
  );

  gir_decode #(.AW(AW)) u_decode (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .rd_rec(rd_rec), .rd_chan(rd_chan), .rd_cnt(rd_cnt),
    .rd_data(rd_data), .wr_data(wr_data)
  );

  gir_steer #(.NCH(NCH), .DW(DW)) u_steer (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .wr_data(wr_data),
    .rec_chan(rec_chan), .rec_type(rec_type), .rx_data(rx_data),
    .bus_wdata(bus_wdata), .rx_pop(rx_pop), .tx_push(tx_push),
    .tx_wdata(tx_wdata), .data_rd(data_rd)
  );

  assign rec_word = {rec_chan, rec_type, rec_cnt};

  always_comb begin
    bus_rdata = '0;
    if (rd_rec)  bus_rdata = DW'(rec_word);
    if (rd_chan) bus_rdata = DW'(rec_chan);
    if (rd_cnt)  bus_rdata = DW'(rec_cnt);
    if (rd_data) bus_rdata = data_rd;
  end

  AST_FF_NO_RX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !type_is_rx(rec_type)) |-> (bus_rdata == {DW{1'b1}} && rx_pop == '0)); // R8
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0 && rx_pop == '0 && tx_push == '0)); // R11
endmodule

// File: tb/gir_router_tb.sv
module gir_router_tb;
  logic        clk = 0, rst_n = 0, iack_start = 0;
  logic [1:0]  win_chan = 0;
  logic [2:0]  win_type = 0;
  logic [11:0] rx_count, tx_space;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic [31:0] rx_data;
  logic [3:0]  rx_pop, tx_push;
  logic [7:0]  tx_wdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gir_router u_dut (.*);

  // {chan(2), type(3), expected record byte(8), rx cause, tx cause}
  localparam logic [14:0] VEC [7] = '{
    {2'd2, 3'b011, 8'h9D, 1'b1, 1'b0},
    {2'd1, 3'b110, 8'h74, 1'b0, 1'b1},
    {2'd3, 3'b111, 8'hFF, 1'b1, 1'b0},
    {2'd0, 3'b010, 8'h16, 1'b0, 1'b1},
    {2'd1, 3'b001, 8'h48, 1'b0, 1'b0},
    {2'd3, 3'b100, 8'hE0, 1'b0, 1'b0},
    {2'd3, 3'b110, 8'hF0, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [1:0] ch, input logic [2:0] ty);
    @(negedge clk); win_chan = ch; win_type = ty; iack_start = 1;
    @(negedge clk); iack_start = 0;
  endtask

  // drive one access at a negedge, sample 2 ns later (before the next edge)
  task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #2;
  endtask

  task automatic idle_bus();
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  initial begin
    rx_count = {3'd7, 3'd5, 3'd2, 3'd1};
    tx_space = {3'd0, 3'd3, 3'd4, 3'd6};
    rx_data  = {8'hA3, 8'hA2, 8'hA1, 8'hA0};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    access(0, 8'h28, 0); check("R1 reset record", bus_rdata, 8'h00);
    access(0, 8'h2B, 0); check("R8 idle rx read", bus_rdata, 8'hFF);
    check("R8 idle no pop", {4'b0, rx_pop}, 8'h00);
    access(1, 8'h2B, 8'h33); check("R10 idle no push", {4'b0, tx_push}, 8'h00);
    idle_bus();

    for (int i = 0; i < 7; i++) begin
      logic [1:0] ch; logic [2:0] ty; logic [7:0] rec; logic rxc, txc;
      {ch, ty, rec, rxc, txc} = VEC[i];
      capture(ch, ty);
      access(0, 8'h28, 0); check("R2 R3 R4 record", bus_rdata, rec);
      access(0, 8'h29, 0); check("R5 channel", bus_rdata, {6'b0, ch});
      access(0, 8'h2A, 0); check("R6 count", bus_rdata, {5'b0, rec[2:0]});
      access(0, 8'h2B, 0);
      if (rxc) begin
        check("R7 pop", {4'b0, rx_pop}, 8'(4'b1 << ch));
        check("R7 data", bus_rdata, 8'hA0 + 8'(ch));
      end else begin
        check("R8 no pop", {4'b0, rx_pop}, 8'h00);
        check("R8 ones", bus_rdata, 8'hFF);
      end
      access(1, 8'h2B, 8'h5A + 8'(i));
      if (txc) begin
        check("R9 push", {4'b0, tx_push}, 8'(4'b1 << ch));
        check("R9 wdata", tx_wdata, 8'h5A + 8'(i));
      end else
        check("R10 no push", {4'b0, tx_push}, 8'h00);
      idle_bus();
    end

    // record frozen without acknowledge (last record F0)
    @(negedge clk); win_chan = 0; win_type = 3'b011; rx_count = 12'hFFF;
    repeat (3) @(negedge clk);
    access(0, 8'h28, 0); check("R2 hold", bus_rdata, 8'hF0);
    access(0, 8'h2C, 0); check("R11 unmapped read", bus_rdata, 8'h00);
    access(1, 8'h28, 8'h77); check("R11 ro write no push", {4'b0, tx_push}, 8'h00);
    idle_bus(); #2;
    check("R11 no select", bus_rdata, 8'h00);
    // counter/timer C/D code passes through
    capture(2'd3, 3'b000);
    access(0, 8'h29, 0); check("R2 timer code", bus_rdata, 8'h03);
    idle_bus();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule